// File: doc/BRIEF.md
# Fine-grain barrier controller

This block is one hardware barrier that synchronises a chosen subset of the wavefronts in a work-group, not the whole group. Each wavefront sends commands over a single request port, one per cycle. A command is a three-bit code plus the ID of the wavefront that issues it. The barrier has to be set up before use. Wavefronts then join or leave it while it runs. A member arrives either by blocking, in which case it stalls until the phase completes, or by marking itself arrived and carrying on.

The block keeps three wavefront bitmaps: members, members that have arrived in the current phase, and stalled waiters. When the last pending member arrives, the phase completes. A one-cycle resume pulse goes to exactly the wavefronts that were stalled, and the arrival state clears so the barrier can be reused. A scheduler uses the resume vector to restart stalled wavefronts and the wait-set vector to hold them back. A sticky error flag records commands that break the usage rules.

Command codes: 0 init, 1 join, 2 leave, 3 wait, 4 arrive, 5 release. Codes 6 and 7 are undefined. NUM_WF must be a power of two.

Top module: `fgb_ctrl`

## Requirements
- R1: After reset the barrier is inactive, both counts are zero, the wait set and resume vector are empty, and the error flag is clear.
- R2: Init (code 0) makes the barrier active and empties the member, arrival and wait sets. This takes effect in the cycle after the request.
- R3: While the barrier is inactive, any command with codes 1 to 5 sets the error flag and changes no other state.
- R4: Join (code 1) by a non-member adds it to the member set and raises the member count by one. Join by an existing member sets the error flag and changes nothing else.
- R5: Wait (code 3) by a member that has not yet arrived adds that member to the arrival set and to the wait set. If this arrival completes the phase, R8 applies instead.
- R6: Arrive (code 4) by a member that has not yet arrived adds it to the arrival set, never to the wait set.
- R7: Leave (code 2) by a member removes it from both the member set and the arrival set. It counts as that member's arrival when deciding whether the phase completes.
- R8: When a wait, arrive or leave leaves no member un-arrived, resume pulses for exactly one cycle on the wavefronts that are in the wait set, including a waiter that completes the phase. The wait and arrival sets then clear and membership is kept.
- R9: Wait or arrive by a non-member, by a member that has already arrived in this phase, and leave by a non-member, each set the error flag and change nothing else.
- R10: Release (code 5) makes the barrier inactive and empties all sets. Pending waiters are not resumed.
- R11: The error flag stays set until reset; init does not clear it.
- R12: Codes 6 and 7 set the error flag and change no other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command is presented this cycle |
| req_op | input | 3 | Command code |
| req_wf | input | WF_W | Issuing wavefront ID |
| resume_o | output | NUM_WF | One-cycle release pulse per wavefront |
| wait_set_o | output | NUM_WF | Wavefronts currently stalled on the barrier |
| member_cnt_o | output | CNT_W | Number of member wavefronts |
| arrive_cnt_o | output | CNT_W | Members arrived in the current phase |
| active_o | output | 1 | Barrier is initialised and not released |
| err_o | output | 1 | Sticky misuse flag |

## Verification
The main phase logic is tested with three kinds of completion. In the first, a waiter, an arriver and a final waiter complete the phase; this shows that the completing wavefront is included in the resume pulse. In the second, a late joiner waits while others leave and arrive; this shows that leave shrinks membership and also completes the phase. In the third, a single member waits alone, which checks that the release is immediate. Separate misuse patterns are used to tell apart each cause of the error flag. These are commands before init, a double join, arrival by a non-member, a double arrival and undefined codes. Each misuse check also confirms that the counts stay unchanged.

// File: rtl/fgb_pkg.sv
package fgb_pkg;
  typedef enum logic [2:0] {
    OP_INIT    = 3'd0,
    OP_JOIN    = 3'd1,
    OP_LEAVE   = 3'd2,
    OP_WAIT    = 3'd3,
    OP_ARRIVE  = 3'd4,
    OP_RELEASE = 3'd5
  } fgb_op_e;

  typedef struct packed {
    logic do_init;
    logic do_join;
    logic do_leave;
    logic do_wait;
    logic do_arrive;
    logic do_release;
    logic bad;
  } fgb_act_t;
endpackage

// File: rtl/fgb_decode.sv
module fgb_decode
  import fgb_pkg::*;
#(
  parameter int NUM_WF = 8,
  parameter int WF_W   = $clog2(NUM_WF)
) (
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [WF_W-1:0]   req_wf,
  input  logic              active,
  input  logic [NUM_WF-1:0] member,
  input  logic [NUM_WF-1:0] arrived,
  output fgb_act_t          act
);
  logic is_mem;
  logic has_arr;

  assign is_mem  = member[req_wf];
  assign has_arr = arrived[req_wf];

  always_comb begin
    act = '0;
    if (req_valid) begin
      case (req_op)
        OP_INIT:    act.do_init = 1'b1;
        OP_JOIN:    if (!active || is_mem) act.bad = 1'b1;
                    else act.do_join = 1'b1;
        OP_LEAVE:   if (!active || !is_mem) act.bad = 1'b1;
                    else act.do_leave = 1'b1;
        OP_WAIT:    if (!active || !is_mem || has_arr) act.bad = 1'b1;
                    else act.do_wait = 1'b1;
        OP_ARRIVE:  if (!active || !is_mem || has_arr) act.bad = 1'b1;
                    else act.do_arrive = 1'b1;
        OP_RELEASE: if (!active) act.bad = 1'b1;
                    else act.do_release = 1'b1;
        default:    act.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fgb_popcnt.sv
module fgb_popcnt #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/fgb_state.sv
module fgb_state
  import fgb_pkg::*;
#(
  parameter int NUM_WF = 8,
  parameter int WF_W   = $clog2(NUM_WF),
  parameter int CNT_W  = $clog2(NUM_WF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  fgb_act_t          act,
  input  logic [WF_W-1:0]   req_wf,
  output logic              active_q,
  output logic [NUM_WF-1:0] member_q,
  output logic [NUM_WF-1:0] arrived_q,
  output logic [NUM_WF-1:0] wait_q,
  output logic [NUM_WF-1:0] resume_q,
  output logic [CNT_W-1:0]  member_cnt_q,
  output logic [CNT_W-1:0]  arrive_cnt_q
);
  logic [NUM_WF-1:0] onehot;
  logic [NUM_WF-1:0] mem_n, arr_n, wt_n, res_n;
  logic              act_n;
  logic              arrival_evt;
  logic [CNT_W-1:0]  mem_cnt_n, arr_cnt_n;

  assign onehot      = NUM_WF'(1) << req_wf;
  assign arrival_evt = act.do_leave | act.do_wait | act.do_arrive;

  always_comb begin
    act_n = active_q;
    mem_n = member_q;
    arr_n = arrived_q;
    wt_n  = wait_q;
    res_n = '0;
    if (act.do_init) begin
      act_n = 1'b1;
      mem_n = '0;
      arr_n = '0;
      wt_n  = '0;
    end
    if (act.do_release) begin
      act_n = 1'b0;
      mem_n = '0;
      arr_n = '0;
      wt_n  = '0;
    end
    if (act.do_join)   mem_n = mem_n | onehot;
    if (act.do_leave) begin
      mem_n = mem_n & ~onehot;
      arr_n = arr_n & ~onehot;
    end
    if (act.do_wait) begin
      arr_n = arr_n | onehot;
      wt_n  = wt_n | onehot;
    end
    if (act.do_arrive) arr_n = arr_n | onehot;
    if (arrival_evt && ((mem_n & ~arr_n) == '0)) begin
      res_n = wt_n;
      wt_n  = '0;
      arr_n = '0;
    end
  end

  fgb_popcnt #(.W(NUM_WF), .CW(CNT_W)) u_cnt_mem (.vec(mem_n), .cnt(mem_cnt_n));
  fgb_popcnt #(.W(NUM_WF), .CW(CNT_W)) u_cnt_arr (.vec(arr_n), .cnt(arr_cnt_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q     <= 1'b0;
      member_q     <= '0;
      arrived_q    <= '0;
      wait_q       <= '0;
      resume_q     <= '0;
      member_cnt_q <= '0;
      arrive_cnt_q <= '0;
    end else begin
      active_q     <= act_n;
      member_q     <= mem_n;
      arrived_q    <= arr_n;
      wait_q       <= wt_n;
      resume_q     <= res_n;
      member_cnt_q <= mem_cnt_n;
      arrive_cnt_q <= arr_cnt_n;
    end
  end
endmodule

// File: rtl/fgb_ctrl.sv
module fgb_ctrl
  import fgb_pkg::*;
#(
  parameter int NUM_WF = 8,
  localparam int WF_W  = $clog2(NUM_WF),
  localparam int CNT_W = $clog2(NUM_WF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [WF_W-1:0]   req_wf,
  output logic [NUM_WF-1:0] resume_o,
  output logic [NUM_WF-1:0] wait_set_o,
  output logic [CNT_W-1:0]  member_cnt_o,
  output logic [CNT_W-1:0]  arrive_cnt_o,
  output logic              active_o,
  output logic              err_o
);
  fgb_act_t          act;
  logic              active_q;
  logic [NUM_WF-1:0] member_q, arrived_q, wait_q, resume_q;
  logic [CNT_W-1:0]  mcnt_q, acnt_q;
  logic              err_q;

  fgb_decode #(.NUM_WF(NUM_WF), .WF_W(WF_W)) u_dec (
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_wf    (req_wf),
    .active    (active_q),
    .member    (member_q),
    .arrived   (arrived_q),
    .act       (act)
  );

  fgb_state #(.NUM_WF(NUM_WF), .WF_W(WF_W), .CNT_W(CNT_W)) u_st (
    .clk          (clk),
    .rst          (rst),
    .act          (act),
    .req_wf       (req_wf),
    .active_q     (active_q),
    .member_q     (member_q),
    .arrived_q    (arrived_q),
    .wait_q       (wait_q),
    .resume_q     (resume_q),
    .member_cnt_q (mcnt_q),
    .arrive_cnt_q (acnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q | act.bad;
  end

  assign resume_o     = resume_q;
  assign wait_set_o   = wait_q;
  assign member_cnt_o = mcnt_q;
  assign arrive_cnt_o = acnt_q;
  assign active_o     = active_q;
  assign err_o        = err_q;
endmodule

// File: rtl/fgb_ctrl_chk.sv
module fgb_ctrl_chk #(
  parameter int NUM_WF = 8,
  parameter int WF_W   = $clog2(NUM_WF),
  parameter int CNT_W  = $clog2(NUM_WF + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [WF_W-1:0]   req_wf,
  input logic [NUM_WF-1:0] resume_o,
  input logic [NUM_WF-1:0] wait_set_o,
  input logic [CNT_W-1:0]  member_cnt_o,
  input logic [CNT_W-1:0]  arrive_cnt_o,
  input logic              active_o,
  input logic              err_o
);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  p_inactive_empty_r10: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> (wait_set_o == '0 && member_cnt_o == '0 && arrive_cnt_o == '0));

  p_arrivals_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    arrive_cnt_o <= member_cnt_o);

  p_waiters_arrived_r5: assert property (@(posedge clk) disable iff (rst)
    CNT_W'($countones(wait_set_o)) <= arrive_cnt_o);

  p_resumed_not_waiting_r8: assert property (@(posedge clk) disable iff (rst)
    (resume_o != '0) |-> ((resume_o & wait_set_o) == '0 && arrive_cnt_o == '0));

  p_arrive_no_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd4 && !wait_set_o[req_wf])
      |=> !wait_set_o[$past(req_wf)]);

  p_inactive_cmd_err_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !active_o && req_op != 3'd0) |=> (err_o && !active_o));
endmodule

bind fgb_ctrl fgb_ctrl_chk #(.NUM_WF(NUM_WF), .WF_W(WF_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .req_wf       (req_wf),
  .resume_o     (resume_o),
  .wait_set_o   (wait_set_o),
  .member_cnt_o (member_cnt_o),
  .arrive_cnt_o (arrive_cnt_o),
  .active_o     (active_o),
  .err_o        (err_o)
);

// File: tb/fgb_ctrl_tb.sv
`timescale 1ns/1ps
module fgb_ctrl_tb;
  localparam int NWF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_wf = '0;
  logic [3:0] resume_o, wait_set_o;
  logic [2:0] member_cnt_o, arrive_cnt_o;
  logic       active_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fgb_ctrl #(.NUM_WF(NWF)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_wf(req_wf),
    .resume_o(resume_o), .wait_set_o(wait_set_o), .member_cnt_o(member_cnt_o),
    .arrive_cnt_o(arrive_cnt_o), .active_o(active_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [2:0]  op;
    logic [1:0]  wf;
    logic        act;
    logic [2:0]  mem;
    logic [2:0]  arr;
    logic [3:0]  wt;
    logic [3:0]  res;
    logic        err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{"R2",  3'd0, 2'd0, 1'b1, 3'd0, 3'd0, 4'h0, 4'h0, 1'b0},
    '{"R4",  3'd1, 2'd0, 1'b1, 3'd1, 3'd0, 4'h0, 4'h0, 1'b0},
    '{"R4",  3'd1, 2'd1, 1'b1, 3'd2, 3'd0, 4'h0, 4'h0, 1'b0},
    '{"R4",  3'd1, 2'd2, 1'b1, 3'd3, 3'd0, 4'h0, 4'h0, 1'b0},
    '{"R5",  3'd3, 2'd0, 1'b1, 3'd3, 3'd1, 4'h1, 4'h0, 1'b0},
    '{"R6",  3'd4, 2'd1, 1'b1, 3'd3, 3'd2, 4'h1, 4'h0, 1'b0},
    '{"R8",  3'd3, 2'd2, 1'b1, 3'd3, 3'd0, 4'h0, 4'h5, 1'b0},
    '{"R4",  3'd1, 2'd3, 1'b1, 3'd4, 3'd0, 4'h0, 4'h0, 1'b0},
    '{"R5",  3'd3, 2'd3, 1'b1, 3'd4, 3'd1, 4'h8, 4'h0, 1'b0},
    '{"R7",  3'd2, 2'd1, 1'b1, 3'd3, 3'd1, 4'h8, 4'h0, 1'b0},
    '{"R6",  3'd4, 2'd0, 1'b1, 3'd3, 3'd2, 4'h8, 4'h0, 1'b0},
    '{"R7",  3'd2, 2'd2, 1'b1, 3'd2, 3'd0, 4'h0, 4'h8, 1'b0},
    '{"R5",  3'd3, 2'd0, 1'b1, 3'd2, 3'd1, 4'h1, 4'h0, 1'b0},
    '{"R10", 3'd5, 2'd0, 1'b0, 3'd0, 3'd0, 4'h0, 4'h0, 1'b0},
    '{"R2",  3'd0, 2'd1, 1'b1, 3'd0, 3'd0, 4'h0, 4'h0, 1'b0}
  };

  task automatic check(input logic [23:0] tag, input logic act, input logic [2:0] mem,
                       input logic [2:0] arr, input logic [3:0] wt,
                       input logic [3:0] res, input logic err);
    checks++;
    if (active_o !== act || member_cnt_o !== mem || arrive_cnt_o !== arr ||
        wait_set_o !== wt || resume_o !== res || err_o !== err) begin
      errors++;
      $display("FAIL %s: actual act=%b mem=%0d arr=%0d wait=%h res=%h err=%b expected act=%b mem=%0d arr=%0d wait=%h res=%h err=%b",
               tag, active_o, member_cnt_o, arrive_cnt_o, wait_set_o, resume_o, err_o,
               act, mem, arr, wt, res, err);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] wf);
    req_valid = 1'b1;
    req_op    = op;
    req_wf    = wf;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    check("R1", 1'b0, 3'd0, 3'd0, 4'h0, 4'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i].op, VEC[i].wf);
      check(VEC[i].tag, VEC[i].act, VEC[i].mem, VEC[i].arr, VEC[i].wt, VEC[i].res, VEC[i].err);
    end

    // R3 command before init, then R11 init keeps the flag
    do_reset();
    cmd(3'd3, 2'd0);
    check("R3", 1'b0, 3'd0, 3'd0, 4'h0, 4'h0, 1'b1);
    cmd(3'd0, 2'd0);
    check("R11", 1'b1, 3'd0, 3'd0, 4'h0, 4'h0, 1'b1);

    // R4 double join
    do_reset();
    cmd(3'd0, 2'd0);
    cmd(3'd1, 2'd0);
    cmd(3'd1, 2'd0);
    check("R4", 1'b1, 3'd1, 3'd0, 4'h0, 4'h0, 1'b1);

    // R9 arrival by non-member, then double arrival
    do_reset();
    cmd(3'd0, 2'd0);
    cmd(3'd1, 2'd0);
    cmd(3'd1, 2'd1);
    cmd(3'd4, 2'd2);
    check("R9", 1'b1, 3'd2, 3'd0, 4'h0, 4'h0, 1'b1);
    cmd(3'd4, 2'd0);
    cmd(3'd3, 2'd0);
    check("R9", 1'b1, 3'd2, 3'd1, 4'h0, 4'h0, 1'b1);

    // R12 undefined codes
    do_reset();
    cmd(3'd0, 2'd0);
    cmd(3'd1, 2'd3);
    cmd(3'd6, 2'd3);
    check("R12", 1'b1, 3'd1, 3'd0, 4'h0, 4'h0, 1'b1);
    cmd(3'd7, 2'd3);
    check("R12", 1'b1, 3'd1, 3'd0, 4'h0, 4'h0, 1'b1);

    // R10 release with a pending waiter gives no resume
    do_reset();
    cmd(3'd0, 2'd0);
    cmd(3'd1, 2'd0);
    cmd(3'd1, 2'd1);
    cmd(3'd3, 2'd0);
    check("R5", 1'b1, 3'd2, 3'd1, 4'h1, 4'h0, 1'b0);
    cmd(3'd5, 2'd1);
    check("R10", 1'b0, 3'd0, 3'd0, 4'h0, 4'h0, 1'b0);
    @(negedge clk);
    check("R10", 1'b0, 3'd0, 3'd0, 4'h0, 4'h0, 1'b0);

    // R8 lone member wait completes immediately, pulse lasts one cycle
    do_reset();
    cmd(3'd0, 2'd0);
    cmd(3'd1, 2'd2);
    cmd(3'd3, 2'd2);
    check("R8", 1'b1, 3'd1, 3'd0, 4'h0, 4'h4, 1'b0);
    @(negedge clk);
    check("R8", 1'b1, 3'd1, 3'd0, 4'h0, 4'h0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule